// File: doc/BRIEF.md
# Boost Converter Startup and Restart Sequencer

This block is the control state machine that starts a battery-fed boost converter driving the USB supply rail and then watches over it. It decides whether boost is wanted from two request paths: a host register path (mode bit, overridden by the high-impedance bit) and a pin path (OTG pin, qualified by an enable bit and a polarity bit). Once boost is wanted and the battery is above the start lockout, it brings the stage up in order. First a linear source charges the intermediate node. Then switching begins at half current limit and steps to full limit. Then it enters the run state.

Comparator flags and a one-microsecond tick are the only timing inputs. Every window is a parameter counted in ticks. A fault shuts the stage off at once, loads a three-bit fault code and emits a one-cycle pulse that clears the host mode bit. A request made through the pin then retries on a fixed delay. A request made through the register waits until the host removes and reissues it.

Top module: `boost_seq`

## Requirements
- R1: Boost is wanted when (mode bit = 1 and high-impedance bit = 0) or (pin-enable bit = 1 and the pin is at its active level). The active level is high when polarity = 1 and low when polarity = 0. The pin path is honoured even when the high-impedance bit = 1.
- R2: After reset all outputs are 0. From off, a wanted boost starts only while the battery is above the start lockout. The linear source enable is 1 in the cycle after the start decision.
- R3: In the linear phase, the PMID-ready flag moves the block to switching with full limit select = 0. If that flag is absent for PRE_US ticks, fault 010 is raised.
- R4: During soft-start, the VBUS-ready flag moves to run with full limit select = 1. Without it, full limit select goes to 1 after SS_HALF_US ticks. Fault 010 follows after a further SS_FULL_US ticks.
- R5: In run, a current-limit flag held for OC_US consecutive ticks causes no fault. Held for OC_US+1 ticks, it raises fault 010.
- R6: While the stage is powered (linear, soft-start or run), faults are detected with priority thermal (101) > over-voltage (001) > battery below running lockout (011) > overload (010).
- R7: On any fault, the linear and switching enables go to 0 and the code is loaded in the same edge. The clear-mode output pulses high for exactly one cycle. The code is held until the stage next reaches run, where it returns to 000.
- R8: If the pin path is wanted when a fault occurs, the linear phase restarts RETRY_FIRST_US ticks after the fault. Later faults restart after RETRY_US ticks.
- R9: If the pin path is not wanted when a fault occurs, the stage stays off while the request remains. It starts again only after the request is removed and reissued.
- R10: When boost stops being wanted, the block returns to off in the next cycle from any state with no fault code. A following request starts at once, without a retry delay.
- R11: Once started, a battery below the start lockout but above the running lockout does not stop or fault the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle strobe each microsecond |
| otg_pin_i | input | 1 | OTG pin level |
| otg_en_i | input | 1 | Pin-path enable bit |
| otg_pol_i | input | 1 | Pin polarity bit, 1 = active high |
| hz_mode_i | input | 1 | High-impedance bit |
| opa_mode_i | input | 1 | Host boost mode bit |
| pmid_ok_i | input | 1 | PMID within 400 mV of battery |
| vbus_ok_i | input | 1 | VBUS at 95% of set point |
| bat_start_ok_i | input | 1 | Battery above start lockout |
| bat_run_ok_i | input | 1 | Battery above running lockout |
| ovp_i | input | 1 | VBUS over-voltage |
| ilim_i | input | 1 | Current limit active |
| thermal_i | input | 1 | Thermal shutdown |
| lin_en_o | output | 1 | Linear precharge source enable |
| sw_en_o | output | 1 | Switching enable |
| ilim_full_o | output | 1 | Current limit select: 0 = 50%, 1 = 100% |
| fault_o | output | 3 | Last fault code |
| clr_opa_o | output | 1 | One-cycle pulse clearing the host mode bit |

## Verification
The enable decision is tried over every combination of polarity and pin level, with and without the pin-enable bit, and with the register path gated by the high-impedance bit. This separates a swapped polarity from a missing override. Each timed window is probed one tick before and exactly at its limit, which catches off-by-one counts. Current-limit bursts of OC_US and OC_US+1 ticks separate a strict "more than" from "at least". Simultaneous fault flags are applied in several combinations to pin down the priority order. A pin-path fault sequence measures both the first and the later retry delays. It also shows that the fault code survives until run is reached.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_PRE, ST_SS_HALF, ST_SS_FULL, ST_RUN, ST_RETRY, ST_HOLD
  } bst_state_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'b000,
    FLT_OVP   = 3'b001,
    FLT_OVLD  = 3'b010,
    FLT_UVLO  = 3'b011,
    FLT_THERM = 3'b101
  } bst_fault_e;
endpackage

// File: rtl/boost_seq_req.sv
module boost_seq_req (
  input  logic otg_pin_i,
  input  logic otg_en_i,
  input  logic otg_pol_i,
  input  logic hz_mode_i,
  input  logic opa_mode_i,
  output logic pin_req_o,
  output logic want_o
);
  logic pin_active;
  always_comb begin
    pin_active = otg_pol_i ? otg_pin_i : ~otg_pin_i;
    pin_req_o  = otg_en_i & pin_active;
    // pin path bypasses hz; register path does not
    want_o     = pin_req_o | (opa_mode_i & ~hz_mode_i);
  end
endmodule

// File: rtl/boost_seq_tmr.sv
module boost_seq_tmr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (tick_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/boost_seq_flt.sv
module boost_seq_flt
  import boost_seq_pkg::*;
(
  input  logic       active_i,
  input  logic       thermal_i,
  input  logic       ovp_i,
  input  logic       bat_run_ok_i,
  input  logic       ovld_i,
  output logic       hit_o,
  output bst_fault_e code_o
);
  always_comb begin
    hit_o  = 1'b0;
    code_o = FLT_NONE;
    if (active_i) begin
      if (thermal_i) begin
        hit_o = 1'b1; code_o = FLT_THERM;
      end else if (ovp_i) begin
        hit_o = 1'b1; code_o = FLT_OVP;
      end else if (!bat_run_ok_i) begin
        hit_o = 1'b1; code_o = FLT_UVLO;
      end else if (ovld_i) begin
        hit_o = 1'b1; code_o = FLT_OVLD;
      end
    end
  end
endmodule

// File: rtl/boost_seq.sv
module boost_seq
  import boost_seq_pkg::*;
#(
  parameter int unsigned PRE_US         = 560,
  parameter int unsigned SS_HALF_US     = 128,
  parameter int unsigned SS_FULL_US     = 384,
  parameter int unsigned OC_US          = 50,
  parameter int unsigned RETRY_FIRST_US = 5200,
  parameter int unsigned RETRY_US       = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_us_i,
  input  logic       otg_pin_i,
  input  logic       otg_en_i,
  input  logic       otg_pol_i,
  input  logic       hz_mode_i,
  input  logic       opa_mode_i,
  input  logic       pmid_ok_i,
  input  logic       vbus_ok_i,
  input  logic       bat_start_ok_i,
  input  logic       bat_run_ok_i,
  input  logic       ovp_i,
  input  logic       ilim_i,
  input  logic       thermal_i,
  output logic       lin_en_o,
  output logic       sw_en_o,
  output logic       ilim_full_o,
  output logic [2:0] fault_o,
  output logic       clr_opa_o
);
  localparam int unsigned M0 = PRE_US > SS_HALF_US ? PRE_US : SS_HALF_US;
  localparam int unsigned M1 = M0 > SS_FULL_US ? M0 : SS_FULL_US;
  localparam int unsigned M2 = M1 > RETRY_FIRST_US ? M1 : RETRY_FIRST_US;
  localparam int unsigned MAXLIM = M2 > RETRY_US ? M2 : RETRY_US;
  localparam int unsigned CW  = $clog2(MAXLIM + 1) + 1;
  localparam int unsigned OCW = $clog2(OC_US + 2) + 1;
  localparam logic [CW-1:0]  PRE_LAST  = CW'(PRE_US - 1);
  localparam logic [CW-1:0]  SSH_LAST  = CW'(SS_HALF_US - 1);
  localparam logic [CW-1:0]  SSF_LAST  = CW'(SS_FULL_US - 1);
  localparam logic [CW-1:0]  RTF_LAST  = CW'(RETRY_FIRST_US - 1);
  localparam logic [CW-1:0]  RTN_LAST  = CW'(RETRY_US - 1);
  localparam logic [OCW-1:0] OC_LAST   = OCW'(OC_US);

  bst_state_e state_q, state_d;
  bst_fault_e flt_code, fault_q;
  logic       pin_req, want;
  logic       flt_hit, ovld, active, phase_exp, rearm, first_q, clr_q;
  logic [CW-1:0]  ph_cnt, ph_lim;
  logic [OCW-1:0] oc_cnt;
  logic           ph_clr, oc_clr;

  boost_seq_req u_req (
    .otg_pin_i  (otg_pin_i),
    .otg_en_i   (otg_en_i),
    .otg_pol_i  (otg_pol_i),
    .hz_mode_i  (hz_mode_i),
    .opa_mode_i (opa_mode_i),
    .pin_req_o  (pin_req),
    .want_o     (want)
  );

  boost_seq_tmr #(.W(CW)) u_ph_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ph_clr),
    .tick_i (tick_us_i),
    .cnt_o  (ph_cnt)
  );

  boost_seq_tmr #(.W(OCW)) u_oc_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (oc_clr),
    .tick_i (tick_us_i),
    .cnt_o  (oc_cnt)
  );

  boost_seq_flt u_flt (
    .active_i     (active),
    .thermal_i    (thermal_i),
    .ovp_i        (ovp_i),
    .bat_run_ok_i (bat_run_ok_i),
    .ovld_i       (ovld),
    .hit_o        (flt_hit),
    .code_o       (flt_code)
  );

  always_comb begin
    unique case (state_q)
      ST_PRE:     ph_lim = PRE_LAST;
      ST_SS_HALF: ph_lim = SSH_LAST;
      ST_SS_FULL: ph_lim = SSF_LAST;
      ST_RETRY:   ph_lim = first_q ? RTF_LAST : RTN_LAST;
      default:    ph_lim = '1;
    endcase
  end

  assign phase_exp = tick_us_i && (ph_cnt == ph_lim);
  assign active = (state_q == ST_PRE) || (state_q == ST_SS_HALF) ||
                  (state_q == ST_SS_FULL) || (state_q == ST_RUN);
  assign ovld = ((state_q == ST_PRE) && phase_exp && !pmid_ok_i) ||
                ((state_q == ST_SS_FULL) && phase_exp && !vbus_ok_i) ||
                ((state_q == ST_RUN) && tick_us_i && ilim_i && (oc_cnt == OC_LAST));
  assign oc_clr = !((state_q == ST_RUN) && ilim_i);

  always_comb begin
    state_d = state_q;
    rearm   = 1'b0;
    if (!want && state_q != ST_OFF) begin
      state_d = ST_OFF;
    end else if (flt_hit) begin
      state_d = pin_req ? ST_RETRY : ST_HOLD;
    end else begin
      unique case (state_q)
        ST_OFF:     if (want && bat_start_ok_i) state_d = ST_PRE;
        ST_PRE:     if (pmid_ok_i) state_d = ST_SS_HALF;
        ST_SS_HALF: if (vbus_ok_i) state_d = ST_RUN;
                    else if (phase_exp) state_d = ST_SS_FULL;
        ST_SS_FULL: if (vbus_ok_i) state_d = ST_RUN;
        ST_RUN:     state_d = ST_RUN;
        ST_RETRY: begin
          if (!pin_req) state_d = ST_HOLD;
          else if (phase_exp) begin
            if (bat_start_ok_i) state_d = ST_PRE;
            else rearm = 1'b1;
          end
        end
        default:    state_d = state_q;
      endcase
    end
  end

  assign ph_clr = (state_d != state_q) || rearm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      fault_q <= FLT_NONE;
      clr_q   <= 1'b0;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      clr_q   <= flt_hit && want;
      if (flt_hit && want)                             fault_q <= flt_code;
      else if (state_d == ST_RUN && state_q != ST_RUN) fault_q <= FLT_NONE;
      if (state_q == ST_OFF)                           first_q <= 1'b1;
      else if (state_q == ST_RETRY && phase_exp)       first_q <= 1'b0;
    end
  end

  assign lin_en_o    = (state_q == ST_PRE);
  assign sw_en_o     = (state_q == ST_SS_HALF) || (state_q == ST_SS_FULL) || (state_q == ST_RUN);
  assign ilim_full_o = (state_q == ST_SS_FULL) || (state_q == ST_RUN);
  assign fault_o     = fault_q;
  assign clr_opa_o   = clr_q;
endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       otg_pin_i,
  input logic       otg_en_i,
  input logic       otg_pol_i,
  input logic       hz_mode_i,
  input logic       opa_mode_i,
  input logic       pmid_ok_i,
  input logic       bat_start_ok_i,
  input logic       lin_en_o,
  input logic       sw_en_o,
  input logic       ilim_full_o,
  input logic [2:0] fault_o,
  input logic       clr_opa_o
);
  logic want_c;
  assign want_c = (otg_en_i && (otg_pin_i == otg_pol_i)) || (opa_mode_i && !hz_mode_i);

  p_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lin_en_o && sw_en_o));
  p_start_needs_bat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lin_en_o) |-> $past(bat_start_ok_i));
  p_sw_after_lin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> ($past(lin_en_o) && $past(pmid_ok_i)));
  p_full_only_sw_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_full_o |-> sw_en_o);
  p_code_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b101});
  p_clr_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_opa_o |=> !clr_opa_o);
  p_fault_stage_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_opa_o |-> (!lin_en_o && !sw_en_o && fault_o != 3'b000));
  p_disable_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !want_c |=> (!lin_en_o && !sw_en_o));
endmodule

bind boost_seq boost_seq_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .otg_pin_i      (otg_pin_i),
  .otg_en_i       (otg_en_i),
  .otg_pol_i      (otg_pol_i),
  .hz_mode_i      (hz_mode_i),
  .opa_mode_i     (opa_mode_i),
  .pmid_ok_i      (pmid_ok_i),
  .bat_start_ok_i (bat_start_ok_i),
  .lin_en_o       (lin_en_o),
  .sw_en_o        (sw_en_o),
  .ilim_full_o    (ilim_full_o),
  .fault_o        (fault_o),
  .clr_opa_o      (clr_opa_o)
);

// File: tb/boost_seq_tb_top.sv
module boost_seq_tb_top;
  localparam int CLK_NS  = 8;
  localparam int PRE     = 560;
  localparam int SSH     = 128;
  localparam int SSF     = 384;
  localparam int OC      = 50;
  localparam int RTF     = 5200;
  localparam int RTN     = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, pin, oen, pol, hz, opa, pmid, vbus, bst, brn, ovp, ilim, therm;
  logic lin, sw, full, clr;
  logic [2:0] flt;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  boost_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .otg_pin_i(pin), .otg_en_i(oen),
    .otg_pol_i(pol), .hz_mode_i(hz), .opa_mode_i(opa), .pmid_ok_i(pmid), .vbus_ok_i(vbus),
    .bat_start_ok_i(bst), .bat_run_ok_i(brn), .ovp_i(ovp), .ilim_i(ilim), .thermal_i(therm),
    .lin_en_o(lin), .sw_en_o(sw), .ilim_full_o(full), .fault_o(flt), .clr_opa_o(clr)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    tick = 1; pin = 0; oen = 0; pol = 1; hz = 0; opa = 0; pmid = 0; vbus = 0;
    bst = 1; brn = 1; ovp = 0; ilim = 0; therm = 0;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic go_run();
    opa = 1; pmid = 1; vbus = 1;
    step(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset lin", lin, 0);
    chk("R2 reset sw", sw, 0);
    chk("R2 reset full", full, 0);
    chk("R2 reset fault", flt, 0);
    chk("R2 reset clr", clr, 0);
  endtask

  task automatic t_enable();
    do_reset();
    oen = 1; pol = 1; pin = 1; step(1);
    chk("R1 pol1 pin1 starts", lin, 1);
    pin = 0; step(1);
    chk("R1 pol1 pin0 off", lin, 0);
    pol = 0; step(1);
    chk("R1 pol0 pin0 starts", lin, 1);
    pin = 1; step(1);
    chk("R1 pol0 pin1 off", lin, 0);
    oen = 0; pin = 0; step(5);
    chk("R1 pin en=0 ignored", lin, 0);
    pol = 1; opa = 1; hz = 1; step(5);
    chk("R1 hz masks mode bit", lin, 0);
    hz = 0; step(1);
    chk("R1 mode bit starts", lin, 1);
    opa = 0; step(1);
    hz = 1; oen = 1; pin = 1; step(1);
    chk("R1 pin path despite hz", lin, 1);
  endtask

  task automatic t_start_lockout();
    do_reset();
    bst = 0; opa = 1; step(10);
    chk("R2 no start below lockout", lin, 0);
    bst = 1; step(1);
    chk("R2 start above lockout", lin, 1);
  endtask

  task automatic t_pre_timeout();
    do_reset();
    opa = 1; step(1);
    chk("R2 lin phase", lin, 1);
    step(PRE - 1);
    chk("R3 lin before limit", lin, 1);
    chk("R3 no fault before limit", flt, 0);
    step(1);
    chk("R3 pre timeout off", lin, 0);
    chk("R3 pre timeout code", flt, 2);
    chk("R7 clr pulse", clr, 1);
    step(1);
    chk("R7 clr single cycle", clr, 0);
    step(100);
    chk("R9 held off while requested", lin, 0);
    opa = 0; step(1);
    opa = 1; step(1);
    chk("R9 restart after reissue", lin, 1);
    chk("R7 code held in pre", flt, 2);
  endtask

  task automatic t_softstart_retry();
    do_reset();
    oen = 1; pin = 1; step(1);
    pmid = 1; step(1);
    chk("R3 switching", sw, 1);
    chk("R3 half limit", full, 0);
    chk("R3 lin off", lin, 0);
    pmid = 0;
    step(SSH - 1);
    chk("R4 half before step", full, 0);
    step(1);
    chk("R4 full after step", full, 1);
    step(SSF - 1);
    chk("R4 no fault before second limit", flt, 0);
    chk("R4 sw before second limit", sw, 1);
    step(1);
    chk("R4 ss timeout code", flt, 2);
    chk("R4 ss timeout off", sw, 0);
    step(RTF - 1);
    chk("R8 no restart before first delay", lin, 0);
    step(1);
    chk("R8 first restart", lin, 1);
    step(PRE);
    chk("R8 second fault", flt, 2);
    step(RTN - 1);
    chk("R8 no restart before later delay", lin, 0);
    step(1);
    chk("R8 later restart", lin, 1);
    chk("R7 code held until run", flt, 2);
    pmid = 1; vbus = 1; step(1);
    chk("R3 to soft-start", sw, 1);
    step(1);
    chk("R4 run full limit", full, 1);
    chk("R7 code cleared in run", flt, 0);
  endtask

  task automatic t_overload();
    do_reset();
    go_run();
    chk("R4 in run", full, 1);
    ilim = 1; step(OC); ilim = 0; step(2);
    chk("R5 burst OC no fault", flt, 0);
    chk("R5 burst OC still on", sw, 1);
    ilim = 1; step(OC + 1);
    chk("R5 sustained fault code", flt, 2);
    chk("R5 sustained off", sw, 0);
  endtask

  task automatic t_priority();
    do_reset();
    go_run();
    therm = 1; ovp = 1; brn = 0; step(1);
    chk("R6 thermal first", flt, 5);
    therm = 0; opa = 0; step(1); opa = 1; step(3);
    ovp = 1; brn = 0; step(1);
    chk("R6 ovp over uvlo", flt, 1);
    ovp = 0; opa = 0; step(1); brn = 1; opa = 1; step(3);
    chk("R6 back in run", flt, 0);
    brn = 0; ilim = 1; step(1);
    chk("R6 uvlo code", flt, 3);
    ilim = 0; brn = 1; opa = 0; pmid = 0; step(1);
    opa = 1; step(1);
    therm = 1; step(1);
    chk("R6 thermal in precharge", flt, 5);
    chk("R6 thermal lin off", lin, 0);
  endtask

  task automatic t_hyst();
    do_reset();
    go_run();
    bst = 0; step(100);
    chk("R11 keeps running", sw, 1);
    chk("R11 no fault", flt, 0);
  endtask

  task automatic t_disable();
    do_reset();
    opa = 1; pmid = 1; step(2); pmid = 0;
    step(SSH + 5);
    chk("R4 in second stage", full, 1);
    opa = 0; step(1);
    chk("R10 disable sw off", sw, 0);
    chk("R10 disable no fault", flt, 0);
    do_reset();
    oen = 1; pin = 1; step(1); step(PRE);
    chk("R10 pin fault", flt, 2);
    step(20);
    oen = 0; step(1);
    oen = 1; step(1);
    chk("R10 reissue starts at once", lin, 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_start_lockout();
    t_pre_timeout();
    t_softstart_retry();
    t_overload();
    t_priority();
    t_hyst();
    t_disable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule